// File: doc/BRIEF.md
# Forward-edge landing pad checker

This block keeps the expected-landing-pad state for forward-edge control-flow integrity in a retiring pipeline. It watches the retirement stream. When forward protection is on and an indirect jump-and-link-register retires, it arms a flag. Jumps whose source register marks them as returns or as software-guarded branches do not arm the flag. The instruction that retires next must then be a landing pad. Its PC must be word aligned. If its embedded 20-bit label is non-zero, the label must equal the upper label field of the guard register x7.

Any violation produces a software-check exception request. The request is a one-cycle valid strobe with a fixed cause code and the forward-edge tval code. The trap unit consumes the request. Instruction decode and trap entry are outside this block. A trap that is taken clears the flag.

Top module: `fwd_lpad_guard`

## Requirements
- R1: When cfi_en_i is 1 and an instruction retires with ret_ijump_i=1 and a ret_rs1_i that is none of 1, 5 or 7, lp_armed_o is 1 from the next cycle.
- R2: An indirect jump whose rs1 is 1 or 5 (return style) or 7 (software guarded) never arms the flag. No jump arms the flag while cfi_en_i is 0.
- R3: A landing pad (ret_lpad_i=1) that retires while the flag is clear has no effect: no request, and the flag stays 0.
- R4: When the flag is set and any instruction retires, the flag is 0 in the next cycle, whether or not a request is raised.
- R5: When the flag is set and a landing pad retires with ret_pc_i[1:0] not 00, a request is raised.
- R6: When the flag is set and a landing pad retires with a non-zero ret_label_i, a request is raised if and only if ret_label_i differs from x7_val_i[31:12] (and the PC is aligned).
- R7: A landing pad with ret_label_i equal to 0 skips the label comparison, so an aligned one never raises a request.
- R8: When the flag is set and the retiring instruction is not a landing pad, a request is raised.
- R9: A request shows as swchk_valid_o=1 for exactly one cycle, the cycle after the retirement. During that cycle swchk_cause_o is 18 and swchk_tval_o is 2. Both are 0 whenever swchk_valid_o is 0.
- R10: trap_taken_i=1 clears the flag for the next cycle and suppresses any check or arming in that cycle. rst_ni low clears the flag and the request.
- R11: A cycle with ret_valid_i=0 neither changes the flag nor raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfi_en_i | input | 1 | Forward-edge protection enable |
| trap_taken_i | input | 1 | A trap is taken this cycle |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_ijump_i | input | 1 | Retiring instruction is an indirect jump-and-link-register |
| ret_lpad_i | input | 1 | Retiring instruction is a landing pad |
| ret_rs1_i | input | 5 | Source register index of the retiring jump |
| ret_label_i | input | 20 | Label embedded in the retiring landing pad |
| ret_pc_i | input | 32 | PC of the retiring instruction |
| x7_val_i | input | 32 | Current value of guard register x7 |
| lp_armed_o | output | 1 | Expected-landing-pad flag |
| swchk_valid_o | output | 1 | Software-check exception request strobe |
| swchk_cause_o | output | 6 | Exception cause, 18 while valid |
| swchk_tval_o | output | 32 | Exception tval code, 2 while valid |

## Verification
The flag and the request are registers. Both reflect a retirement in the cycle after the edge on which that retirement is sampled, and neither output has a combinational path. The bench drives each retirement on a falling edge and lets a behavioural model take the same inputs on the rising edge. On the next falling edge it compares the flag, strobe, cause and tval with the model, so every comparison lands exactly one cycle after its stimulus. Directed sequences cover each exempt register, misalignment, label match and mismatch, and traps; a random phase then mixes them.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned REG_IDX_W   = 5;
  localparam int unsigned CAUSE_W     = 6;
  localparam int unsigned SWCHK_CAUSE = 18;
  localparam int unsigned FWD_TVAL    = 2;
  localparam int unsigned NUM_EXEMPT  = 3;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  // return-style links (x1, x5) and the software-guarded register (x7)
  localparam reg_idx_t EXEMPT_REGS [NUM_EXEMPT] = '{5'd1, 5'd5, 5'd7};

  typedef struct packed {
    logic not_pad;
    logic misaligned;
    logic label_bad;
  } lp_viol_t;
endpackage

// File: rtl/lpc_arm_dec.sv
module lpc_arm_dec
  import lpc_pkg::*;
(
  input  logic     en_i,
  input  logic     valid_i,
  input  logic     ijump_i,
  input  reg_idx_t rs1_i,
  output logic     arm_o
);
  logic [NUM_EXEMPT-1:0] hit;

  for (genvar g = 0; g < NUM_EXEMPT; g++) begin : g_exempt
    assign hit[g] = (rs1_i == EXEMPT_REGS[g]);
  end

  assign arm_o = en_i && valid_i && ijump_i && !(|hit);
endmodule

// File: rtl/lpc_pad_chk.sv
module lpc_pad_chk
  import lpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LBL_W      = 20,
  parameter int unsigned LBL_LSB    = 12,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic             armed_i,
  input  logic             valid_i,
  input  logic             lpad_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [LBL_W-1:0] label_i,
  input  logic [XLEN-1:0]  guard_i,
  output logic             consume_o,
  output lp_viol_t         viol_o,
  output logic             viol_any_o
);
  logic             label_nz;
  logic [LBL_W-1:0] guard_lbl;
  logic             unused_bits;

  assign guard_lbl = guard_i[LBL_LSB +: LBL_W];
  assign label_nz  = |label_i;
  assign consume_o = armed_i && valid_i;

  always_comb begin
    viol_o            = '0;
    viol_o.not_pad    = consume_o && !lpad_i;
    viol_o.misaligned = consume_o && lpad_i && (|pc_i[ALIGN_BITS-1:0]);
    // label compare only when the embedded label is non-zero
    viol_o.label_bad  = consume_o && lpad_i && !(|pc_i[ALIGN_BITS-1:0])
                        && label_nz && (label_i != guard_lbl);
  end

  assign viol_any_o  = |viol_o;
  assign unused_bits = ^{pc_i[XLEN-1:ALIGN_BITS], guard_i};
endmodule

// File: rtl/lpc_state.sv
module lpc_state
  import lpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic               valid_i,
  input  logic               en_i,
  input  logic               arm_i,
  input  logic               consume_i,
  input  logic               viol_i,
  output logic               armed_o,
  output logic               req_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    tval_o
);
  logic armed_d, req_d;

  always_comb begin
    armed_d = armed_o;
    req_d   = 1'b0;
    if (trap_i) begin
      armed_d = 1'b0;
    end else if (consume_i) begin
      armed_d = 1'b0;
      req_d   = viol_i;
    end else if (arm_i) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      armed_o <= armed_d;
      req_o   <= req_d;
    end
  end

  assign cause_o = req_o ? CAUSE_W'(SWCHK_CAUSE) : '0;
  assign tval_o  = req_o ? XLEN'(FWD_TVAL) : '0;

  // R1
  arm_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(armed_o) && armed_o) |-> $past(en_i && valid_i && !trap_i));
  // R4
  flag_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && valid_i) |=> !armed_o);
  // R9
  req_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R9
  req_from_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ($past(armed_o) && $past(valid_i)));
  // R10
  trap_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (!armed_o && !req_o));
  // R11
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !trap_i) |=> ($stable(armed_o) && !req_o));
endmodule

// File: rtl/fwd_lpad_guard.sv
module fwd_lpad_guard
  import lpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LBL_W      = 20,
  parameter int unsigned LBL_LSB    = 12,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfi_en_i,
  input  logic               trap_taken_i,
  input  logic               ret_valid_i,
  input  logic               ret_ijump_i,
  input  logic               ret_lpad_i,
  input  logic [REG_IDX_W-1:0] ret_rs1_i,
  input  logic [LBL_W-1:0]   ret_label_i,
  input  logic [XLEN-1:0]    ret_pc_i,
  input  logic [XLEN-1:0]    x7_val_i,
  output logic               lp_armed_o,
  output logic               swchk_valid_o,
  output logic [CAUSE_W-1:0] swchk_cause_o,
  output logic [XLEN-1:0]    swchk_tval_o
);
  logic     arm, consume, viol_any;
  lp_viol_t viol;
  logic     unused_viol;

  lpc_arm_dec i_arm_dec (
    .en_i    (cfi_en_i),
    .valid_i (ret_valid_i),
    .ijump_i (ret_ijump_i),
    .rs1_i   (ret_rs1_i),
    .arm_o   (arm)
  );

  lpc_pad_chk #(
    .XLEN(XLEN), .LBL_W(LBL_W), .LBL_LSB(LBL_LSB), .ALIGN_BITS(ALIGN_BITS)
  ) i_pad_chk (
    .armed_i    (lp_armed_o),
    .valid_i    (ret_valid_i),
    .lpad_i     (ret_lpad_i),
    .pc_i       (ret_pc_i),
    .label_i    (ret_label_i),
    .guard_i    (x7_val_i),
    .consume_o  (consume),
    .viol_o     (viol),
    .viol_any_o (viol_any)
  );

  lpc_state #(.XLEN(XLEN)) i_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_i    (trap_taken_i),
    .valid_i   (ret_valid_i),
    .en_i      (cfi_en_i),
    .arm_i     (arm),
    .consume_i (consume),
    .viol_i    (viol_any),
    .armed_o   (lp_armed_o),
    .req_o     (swchk_valid_o),
    .cause_o   (swchk_cause_o),
    .tval_o    (swchk_tval_o)
  );

  assign unused_viol = ^viol;

  // R2
  exempt_no_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_armed_o && ret_valid_i && ret_ijump_i && !trap_taken_i &&
     (ret_rs1_i == 5'd1 || ret_rs1_i == 5'd5 || ret_rs1_i == 5'd7)) |=> !lp_armed_o);
  // R3
  idle_pad_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_armed_o && ret_valid_i && ret_lpad_i) |=> !swchk_valid_o);
  // R8
  missing_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_armed_o && ret_valid_i && !ret_lpad_i && !trap_taken_i) |=> swchk_valid_o);
endmodule

// File: tb/test_fwd_lpad_guard.sv
`timescale 1ns/1ps
module test_fwd_lpad_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, trap = 1'b0, rv = 1'b0, ij = 1'b0, lp = 1'b0;
  logic [4:0]  rs1 = '0;
  logic [19:0] lbl = '0;
  logic [31:0] pc = '0, x7 = '0;
  logic        armed, req;
  logic [5:0]  cause;
  logic [31:0] tval;

  int n_checks = 0, n_fail = 0;
  bit m_arm = 0, m_req = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fwd_lpad_guard i_fwd_lpad_guard (
    .clk_i(clk), .rst_ni(rst_n), .cfi_en_i(en), .trap_taken_i(trap),
    .ret_valid_i(rv), .ret_ijump_i(ij), .ret_lpad_i(lp), .ret_rs1_i(rs1),
    .ret_label_i(lbl), .ret_pc_i(pc), .x7_val_i(x7),
    .lp_armed_o(armed), .swchk_valid_o(req), .swchk_cause_o(cause),
    .swchk_tval_o(tval)
  );

  task automatic compare(string tag);
    int ec, et;
    ec = m_req ? 18 : 0;
    et = m_req ? 2 : 0;
    n_checks++;
    if (armed !== m_arm || req !== m_req || cause !== 6'(ec) || tval !== 32'(et)) begin
      n_fail++;
      $display("FAIL %s: armed=%0b req=%0b cause=%0d tval=%0d expected armed=%0b req=%0b cause=%0d tval=%0d",
               tag, armed, req, cause, tval, m_arm, m_req, ec, et);
    end
  endtask

  // behavioural expectation, applied at the rising edge
  task automatic model_step();
    bit nr;
    nr = 0;
    if (trap) m_arm = 0;
    else if (rv) begin
      if (m_arm) begin
        if (!lp) nr = 1;
        else if (pc[1:0] != 2'b00) nr = 1;
        else if (lbl != 0 && lbl != x7[31:12]) nr = 1;
        m_arm = 0;
      end else if (ij && en && !(rs1 inside {5'd1, 5'd5, 5'd7})) m_arm = 1;
    end
    m_req = nr;
  endtask

  task automatic cyc(bit t_rv, bit t_ij, bit t_lp, int t_rs1, int t_lbl,
                     logic [31:0] t_pc, logic [31:0] t_x7, bit t_trap, string tag);
    rv = t_rv; ij = t_ij; lp = t_lp; rs1 = 5'(t_rs1); lbl = 20'(t_lbl);
    pc = t_pc; x7 = t_x7; trap = t_trap;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic jmp(int r, string tag);
    cyc(1, 1, 0, r, 0, 32'h1000, 32'h0, 0, tag);
  endtask

  task automatic pad(int l, logic [31:0] p, logic [31:0] g, string tag);
    cyc(1, 0, 1, 0, l, p, g, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    compare("R10 after reset");

    // R1 arming and R7 zero label
    jmp(10, "R1 arm x10");
    pad(0, 32'h2000, 32'h0, "R7 zero label pass");
    // R2 exempt registers
    jmp(1, "R2 x1 exempt");
    jmp(5, "R2 x5 exempt");
    jmp(7, "R2 x7 exempt");
    en = 1'b0;
    jmp(10, "R2 disabled no arm");
    en = 1'b1;
    // R3 pad with flag clear
    pad(5, 32'h2002, 32'h0, "R3 idle pad nop");
    // R5 misaligned pads
    jmp(6, "R1 arm x6");
    pad(0, 32'h2002, 32'h0, "R5 misaligned pc");
    jmp(6, "R1 arm");
    pad(0, 32'h2001, 32'h0, "R5 misaligned pc bit0");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9 single pulse");
    // R6 labels
    jmp(12, "R1 arm");
    pad(20'h12345, 32'h2000, 32'h12345_abc, "R6 label match");
    jmp(12, "R1 arm");
    pad(20'h12345, 32'h2000, 32'h12346_000, "R6 label mismatch");
    jmp(12, "R1 arm");
    pad(20'hfffff, 32'h2004, 32'hfffff_fff, "R6 label max match");
    jmp(12, "R1 arm");
    pad(0, 32'h2000, 32'hdead_beef, "R7 zero label any x7");
    // R8 missing pad
    jmp(15, "R1 arm");
    jmp(15, "R8 jump instead of pad");
    cyc(1, 0, 0, 0, 0, 32'h3000, 0, 0, "R4 flag stays clear");
    // R11 idle cycles keep flag
    jmp(20, "R1 arm");
    cyc(0, 0, 1, 0, 0, 32'h3001, 0, 0, "R11 idle keeps flag");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11 idle keeps flag");
    pad(0, 32'h3000, 0, "R4 pad clears");
    // R10 trap clears
    jmp(20, "R1 arm");
    cyc(1, 0, 0, 0, 0, 32'h3000, 0, 1, "R10 trap clears no req");
    jmp(20, "R1 arm");
    rst_n = 1'b0; m_arm = 0; m_req = 0;
    @(negedge clk);
    compare("R10 reset clears flag");
    rst_n = 1'b1;

    // mixed phase
    for (int i = 0; i < 3000; i++) begin
      int k, r, l;
      logic [31:0] g, p;
      k = $urandom_range(0, 9);
      r = $urandom_range(0, 31);
      l = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 7);
      g = {20'($urandom_range(0, 7)), 12'($urandom)};
      p = {$urandom} & 32'hffff_fff0 | 32'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0);
      en = ($urandom_range(0, 7) != 0);
      cyc($urandom_range(0, 5) != 0, k < 4, k >= 4 && k < 8, r, l, p, g,
          $urandom_range(0, 19) == 0, "R9 mixed");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule